// File: doc/BRIEF.md
# Operand Effective Address Unit

This block works out where the operand of an instruction lives, for an 8-bit processor with a 16-bit, byte-wide address space. The instruction sequencer gives it the addressing mode, the one or two instruction bytes that follow the opcode, the two index registers and the address of the following instruction. One clock edge later the block returns one of three results. The first is a memory address with a memory-reference flag. The second is an immediate value with an immediate flag, for when the operand is carried in the instruction stream. The third is a branch target with a branch flag.

Memory-referencing modes cover a zero-page byte address, a full two-byte address and an index register plus an unsigned byte offset. An offset of zero through an index register gives plain register-indirect access. Relative mode adds a signed byte to the next-instruction address. Inherent mode raises none of the three flags, so a downstream memory port knows no access is wanted. All sums wrap modulo 2^16.

The mode arrives already encoded on a 3-bit input. For example, a load-accumulator opcode maps to the immediate-byte, zero-page or full-address code, and a register-to-register transfer maps to the inherent code.

Top module: `ea_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `res_valid` is 0 and `eff_addr`, `imm_value`, `br_target`, `mem_ref`, `imm_flag` and `br_flag` are all 0.
- R2: Mode code 3 (zero page): `eff_addr` = {8'h00, first byte}, `mem_ref`=1. The second byte has no effect.
- R3: Mode code 4 (full address): `eff_addr` = {first byte, second byte}, with the first byte being the high byte, and `mem_ref`=1.
- R4: Mode codes 5 and 6 (indexed through X and Y respectively): `eff_addr` = index register + zero-extended first byte, modulo 2^16, and `mem_ref`=1. An offset of 0 returns the index register itself.
- R5: Mode code 7 (relative): `br_target` = `next_pc` + sign-extended first byte, modulo 2^16, with `br_flag`=1 and `mem_ref`=0.
- R6: Mode codes 1 and 2 (immediate byte, immediate word): `imm_flag`=1 and `mem_ref`=0. `imm_value` is {8'h00, first byte} for code 1 and {first byte, second byte} for code 2.
- R7: Mode code 0 (inherent): `mem_ref`, `imm_flag` and `br_flag` are all 0. Fields that do not belong to the decoded mode read 0.
- R8: The result appears exactly one cycle after `op_valid`. When `op_valid` is low, `res_valid` drops on the next cycle and the result fields keep their previous values.
- R9: At most one of `mem_ref`, `imm_flag` and `br_flag` is set at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Request qualifier |
| mode | input | 3 | Addressing mode code (0 inherent, 1 imm byte, 2 imm word, 3 zero page, 4 full address, 5 indexed X, 6 indexed Y, 7 relative) |
| opd_first | input | 8 | First byte after the opcode |
| opd_second | input | 8 | Second byte after the opcode |
| idx_x | input | 16 | Index register X |
| idx_y | input | 16 | Index register Y |
| next_pc | input | 16 | Address of the following instruction |
| res_valid | output | 1 | Result qualifier |
| eff_addr | output | 16 | Memory operand address |
| imm_value | output | 16 | Immediate operand value |
| br_target | output | 16 | Branch destination |
| mem_ref | output | 1 | Operand is in memory at `eff_addr` |
| imm_flag | output | 1 | Operand is `imm_value` |
| br_flag | output | 1 | `br_target` is valid |

## Verification
A wrong offset extension or a wrong carry shows up in `eff_addr` or `br_target` on the cycle after the request. It appears only for offsets with bit 7 set or for bases near $FFFF, so the bench sweeps every offset over bases that straddle both wrap points. A wrong mode selection shows up as a wrong flag, or as a non-zero unused field, on that same cycle. A fault in the result register shows up as lost values on the idle cycle after a request.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int ADDR_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int NUM_IDX = 2;

    typedef enum logic [2:0] {
        MODE_INH   = 3'd0,
        MODE_IMM8  = 3'd1,
        MODE_IMM16 = 3'd2,
        MODE_ZPG   = 3'd3,
        MODE_FULL  = 3'd4,
        MODE_IDX_X = 3'd5,
        MODE_IDX_Y = 3'd6,
        MODE_REL   = 3'd7
    } ea_mode_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] imm;
        logic [ADDR_W-1:0] target;
        logic              mem_ref;
        logic              imm_flag;
        logic              br_flag;
    } ea_result_t;

    function automatic logic [ADDR_W-1:0] zext_byte(input logic [BYTE_W-1:0] b);
        return {{(ADDR_W-BYTE_W){1'b0}}, b};
    endfunction

    function automatic logic [ADDR_W-1:0] join_bytes(input logic [BYTE_W-1:0] hi,
                                                    input logic [BYTE_W-1:0] lo);
        return {hi, lo};
    endfunction

    // Index of the index register used by an indexed mode code.
    function automatic int idx_sel(input ea_mode_e m);
        return (m == MODE_IDX_Y) ? 1 : 0;
    endfunction

endpackage

// File: rtl/ea_offset_add.sv
module ea_offset_add #(
    parameter int AW         = 16,
    parameter int BW         = 8,
    parameter bit SIGNED_OFS = 1'b0
) (
    input  logic [AW-1:0] base,
    input  logic [BW-1:0] ofs,
    output logic [AW-1:0] sum
);
    localparam int EXT_W = AW - BW;

    logic [AW-1:0] ofs_ext;

    generate
        if (SIGNED_OFS) begin : g_signed
            assign ofs_ext = {{EXT_W{ofs[BW-1]}}, ofs};
        end else begin : g_unsigned
            assign ofs_ext = {{EXT_W{1'b0}}, ofs};
        end
    endgenerate

    // Width-limited sum: wraps modulo 2^AW.
    assign sum = base + ofs_ext;

    always_comb begin
        if (!SIGNED_OFS && ofs == '0) begin
            a_r4_zero_offset_passes: assert (sum == base);
        end
    end
endmodule

// File: rtl/ea_mode_mux.sv
module ea_mode_mux
    import ea_pkg::*;
(
    input  ea_mode_e          mode,
    input  logic [BYTE_W-1:0] opd_first,
    input  logic [BYTE_W-1:0] opd_second,
    input  logic [ADDR_W-1:0] idx_sum [NUM_IDX],
    input  logic [ADDR_W-1:0] rel_sum,
    output ea_result_t        res
);
    always_comb begin
        res = '0;
        unique case (mode)
            MODE_INH: ;
            MODE_IMM8: begin
                res.imm      = zext_byte(opd_first);
                res.imm_flag = 1'b1;
            end
            MODE_IMM16: begin
                res.imm      = join_bytes(opd_first, opd_second);
                res.imm_flag = 1'b1;
            end
            MODE_ZPG: begin
                res.addr    = zext_byte(opd_first);
                res.mem_ref = 1'b1;
            end
            MODE_FULL: begin
                res.addr    = join_bytes(opd_first, opd_second);
                res.mem_ref = 1'b1;
            end
            MODE_IDX_X, MODE_IDX_Y: begin
                res.addr    = idx_sum[idx_sel(mode)];
                res.mem_ref = 1'b1;
            end
            MODE_REL: begin
                res.target  = rel_sum;
                res.br_flag = 1'b1;
            end
            default: ;
        endcase
    end

    always_comb begin
        a_r9_single_kind: assert ($onehot0({res.mem_ref, res.imm_flag, res.br_flag}));
    end
endmodule

// File: rtl/ea_unit.sv
module ea_unit
    import ea_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        op_valid,
    input  logic [2:0]  mode,
    input  logic [7:0]  opd_first,
    input  logic [7:0]  opd_second,
    input  logic [15:0] idx_x,
    input  logic [15:0] idx_y,
    input  logic [15:0] next_pc,
    output logic        res_valid,
    output logic [15:0] eff_addr,
    output logic [15:0] imm_value,
    output logic [15:0] br_target,
    output logic        mem_ref,
    output logic        imm_flag,
    output logic        br_flag
);
    logic [ADDR_W-1:0] idx_regs [NUM_IDX];
    logic [ADDR_W-1:0] idx_sum  [NUM_IDX];
    logic [ADDR_W-1:0] rel_sum;
    ea_result_t        res_d;
    ea_result_t        res_q;
    logic              valid_q;

    assign idx_regs[0] = idx_x;
    assign idx_regs[1] = idx_y;

    generate
        for (genvar i = 0; i < NUM_IDX; i++) begin : g_idx
            ea_offset_add #(.AW(ADDR_W), .BW(BYTE_W), .SIGNED_OFS(1'b0)) u_add (
                .base (idx_regs[i]),
                .ofs  (opd_first),
                .sum  (idx_sum[i])
            );
        end
    endgenerate

    ea_offset_add #(.AW(ADDR_W), .BW(BYTE_W), .SIGNED_OFS(1'b1)) u_rel (
        .base (next_pc),
        .ofs  (opd_first),
        .sum  (rel_sum)
    );

    ea_mode_mux u_mux (
        .mode       (ea_mode_e'(mode)),
        .opd_first  (opd_first),
        .opd_second (opd_second),
        .idx_sum    (idx_sum),
        .rel_sum    (rel_sum),
        .res        (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= op_valid;
            if (op_valid) begin
                res_q <= res_d;
            end
        end
    end

    assign res_valid = valid_q;
    assign eff_addr  = res_q.addr;
    assign imm_value = res_q.imm;
    assign br_target = res_q.target;
    assign mem_ref   = res_q.mem_ref;
    assign imm_flag  = res_q.imm_flag;
    assign br_flag   = res_q.br_flag;

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!res_valid && !mem_ref && !imm_flag && !br_flag && eff_addr == '0));

    // R8
    a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> res_valid);

    a_r8_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> (!res_valid && $stable(eff_addr) && $stable(br_target) && $stable(imm_value)));

    // R2
    a_r2_zero_page: assert property (@(posedge clk) disable iff (rst)
        (op_valid && mode == 3'd3) |=> (mem_ref && eff_addr[15:8] == 8'h00
                                        && eff_addr[7:0] == $past(opd_first)));

    // R4
    a_r4_indirect_x: assert property (@(posedge clk) disable iff (rst)
        (op_valid && mode == 3'd5 && opd_first == 8'h00) |=> (eff_addr == $past(idx_x)));

    // R5
    a_r5_rel_no_memory: assert property (@(posedge clk) disable iff (rst)
        (op_valid && mode == 3'd7) |=> (br_flag && !mem_ref && eff_addr == '0));

    // R7
    a_r7_inherent_quiet: assert property (@(posedge clk) disable iff (rst)
        (op_valid && mode == 3'd0) |=> (!mem_ref && !imm_flag && !br_flag));

    // R9
    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_ref, imm_flag, br_flag}));
endmodule

// File: tb/ea_unit_bench.sv
module ea_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic [7:0]  opd_first = 8'h00;
    logic [7:0]  opd_second = 8'h00;
    logic [15:0] idx_x = 16'h0000;
    logic [15:0] idx_y = 16'h0000;
    logic [15:0] next_pc = 16'h0000;
    logic        res_valid;
    logic [15:0] eff_addr, imm_value, br_target;
    logic        mem_ref, imm_flag, br_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ea_unit u_ea_unit (
        .clk(clk), .rst(rst), .op_valid(op_valid), .mode(mode),
        .opd_first(opd_first), .opd_second(opd_second),
        .idx_x(idx_x), .idx_y(idx_y), .next_pc(next_pc),
        .res_valid(res_valid), .eff_addr(eff_addr), .imm_value(imm_value),
        .br_target(br_target), .mem_ref(mem_ref), .imm_flag(imm_flag), .br_flag(br_flag)
    );

    function automatic logic [51:0] pack_out(logic v, logic [15:0] a, logic [15:0] i,
                                             logic [15:0] t, logic m, logic f, logic b);
        return {v, a, i, t, m, f, b};
    endfunction

    task automatic check(string req, logic [51:0] act, logic [51:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one request on the falling edge; sample after the next rising edge.
    task automatic issue(logic [2:0] m, logic [7:0] b0, logic [7:0] b1,
                         logic [15:0] x, logic [15:0] y, logic [15:0] pc);
        @(negedge clk);
        op_valid = 1'b1; mode = m; opd_first = b0; opd_second = b1;
        idx_x = x; idx_y = y; next_pc = pc;
        @(posedge clk);
        #2;
    endtask

    function automatic logic [15:0] rel_exp(logic [15:0] pc, logic [7:0] o);
        int s;
        s = (o > 8'd127) ? int'(o) - 256 : int'(o);
        return 16'((int'(pc) + s) & 32'hFFFF);
    endfunction

    initial begin
        logic [15:0] bases [4];
        logic [51:0] last;
        bases[0] = 16'h0000; bases[1] = 16'hA13F; bases[2] = 16'hFFF0; bases[3] = 16'h8000;

        repeat (3) @(posedge clk);
        #2;
        // R1: during reset
        check("R1", pack_out(res_valid, eff_addr, imm_value, br_target, mem_ref, imm_flag, br_flag), 52'd0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #2;
        check("R1", pack_out(res_valid, eff_addr, imm_value, br_target, mem_ref, imm_flag, br_flag), 52'd0);

        // R2: zero page, second byte varied and ignored
        for (int b = 0; b < 256; b++) begin
            issue(3'd3, 8'(b), 8'(b) ^ 8'h5A, 16'h1234, 16'h4321, 16'h2000);
            check("R2", pack_out(res_valid, eff_addr, imm_value, br_target, mem_ref, imm_flag, br_flag),
                  pack_out(1'b1, {8'h00, 8'(b)}, 16'h0, 16'h0, 1'b1, 1'b0, 1'b0));
        end

        // R3: full address, high byte first
        for (int b = 0; b < 256; b++) begin
            issue(3'd4, 8'(b), ~8'(b), 16'h0, 16'h0, 16'h0);
            check("R3", pack_out(res_valid, eff_addr, imm_value, br_target, mem_ref, imm_flag, br_flag),
                  pack_out(1'b1, {8'(b), ~8'(b)}, 16'h0, 16'h0, 1'b1, 1'b0, 1'b0));
        end

        // R4: indexed through X and Y, every offset, bases across the wrap point
        for (int k = 0; k < 4; k++) begin
            for (int b = 0; b < 256; b++) begin
                issue(3'd5, 8'(b), 8'hFF, bases[k], ~bases[k], 16'h0);
                check("R4 X", pack_out(res_valid, eff_addr, imm_value, br_target, mem_ref, imm_flag, br_flag),
                      pack_out(1'b1, 16'((32'(bases[k]) + b) & 32'hFFFF), 16'h0, 16'h0, 1'b1, 1'b0, 1'b0));
                issue(3'd6, 8'(b), 8'h00, ~bases[k], bases[k], 16'h0);
                check("R4 Y", pack_out(res_valid, eff_addr, imm_value, br_target, mem_ref, imm_flag, br_flag),
                      pack_out(1'b1, 16'((32'(bases[k]) + b) & 32'hFFFF), 16'h0, 16'h0, 1'b1, 1'b0, 1'b0));
            end
        end
        // R4: worked example X=$A13F + $0A
        issue(3'd5, 8'h0A, 8'h00, 16'hA13F, 16'h0, 16'h0);
        check("R4 example", {36'd0, eff_addr}, {36'd0, 16'hA149});

        // R5: relative, signed offset, bases across both wrap points
        for (int k = 0; k < 4; k++) begin
            for (int b = 0; b < 256; b++) begin
                issue(3'd7, 8'(b), 8'h33, 16'hFFFF, 16'h0, bases[k] + 16'h0002);
                check("R5", pack_out(res_valid, eff_addr, imm_value, br_target, mem_ref, imm_flag, br_flag),
                      pack_out(1'b1, 16'h0, 16'h0, rel_exp(bases[k] + 16'h0002, 8'(b)), 1'b0, 1'b0, 1'b1));
            end
        end
        issue(3'd7, 8'hFE, 8'h00, 16'h0, 16'h0, 16'h1002);
        check("R5 example", {36'd0, br_target}, {36'd0, 16'h1000});

        // R6: immediate byte and word
        for (int b = 0; b < 256; b++) begin
            issue(3'd1, 8'(b), 8'hC3, 16'h0, 16'h0, 16'h0);
            check("R6 byte", pack_out(res_valid, eff_addr, imm_value, br_target, mem_ref, imm_flag, br_flag),
                  pack_out(1'b1, 16'h0, {8'h00, 8'(b)}, 16'h0, 1'b0, 1'b1, 1'b0));
            issue(3'd2, 8'(b), 8'(255 - b), 16'h0, 16'h0, 16'h0);
            check("R6 word", pack_out(res_valid, eff_addr, imm_value, br_target, mem_ref, imm_flag, br_flag),
                  pack_out(1'b1, 16'h0, {8'(b), 8'(255 - b)}, 16'h0, 1'b0, 1'b1, 1'b0));
        end

        // R7: inherent with busy inputs
        for (int b = 0; b < 16; b++) begin
            issue(3'd0, 8'(b * 17), 8'hA5, 16'hFFFF, 16'h1357, 16'hBEEF);
            check("R7", pack_out(res_valid, eff_addr, imm_value, br_target, mem_ref, imm_flag, br_flag),
                  pack_out(1'b1, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0));
        end

        // R8: idle cycles drop the qualifier and keep the result
        issue(3'd4, 8'h9C, 8'h21, 16'h0, 16'h0, 16'h0);
        last = pack_out(1'b1, 16'h9C21, 16'h0, 16'h0, 1'b1, 1'b0, 1'b0);
        check("R8", pack_out(res_valid, eff_addr, imm_value, br_target, mem_ref, imm_flag, br_flag), last);
        @(negedge clk);
        op_valid = 1'b0; mode = 3'd3; opd_first = 8'h11; opd_second = 8'h22;
        for (int c = 0; c < 3; c++) begin
            @(posedge clk);
            #2;
            check("R8 hold", pack_out(res_valid, eff_addr, imm_value, br_target, mem_ref, imm_flag, br_flag),
                  {1'b0, last[50:0]});
        end

        // R1: reset in the middle of traffic clears everything
        issue(3'd7, 8'h10, 8'h00, 16'h0, 16'h0, 16'h4000);
        @(negedge clk);
        rst = 1'b1; op_valid = 1'b1;
        @(posedge clk);
        #2;
        check("R1 mid-run", pack_out(res_valid, eff_addr, imm_value, br_target, mem_ref, imm_flag, br_flag), 52'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule